// File: doc/BRIEF.md
# Time-Division Multiplexed Serial Port

This block connects a parallel word stream to a time-division multiplexed serial line. It has two sections that share nothing: a receiver that turns serial bits into words, and a transmitter that turns words into serial bits. Each section has its own bit clock, frame sync and data line. Both are driven from outside and sampled with the system clock. The bit clock may run at no more than a quarter of the system clock.

A frame begins at a frame-sync edge and holds up to 128 slots. Each slot carries one word of 8 or 16 bits, and a per-slot mask marks each slot as used or skipped. Each section has its own static settings: sampling edge, sync polarity, a delay of 0 to 3 bits from sync to first data bit, bit order, word width and slot count. The receiver delivers one word per used slot on a ready/valid output. The transmitter takes one word per used slot from a ready/valid input into a single holding register.

Top module: `tdm_port`

## Requirements
- R1: After reset, rx_valid, tx_oe and all four flags are 0, and tx_ready is 1.
- R2: The configuration word is laid out as follows: bits [6:0] hold the slot count minus one, bits [8:7] the sync delay, bit 9 selects 16-bit words (0 = 8-bit), bit 10 selects LSB first, bit 11 selects an active-high sync and bit 12 selects rising-edge sampling. In 8-bit mode, received words have bits [15:8] at zero and transmit bits [15:8] are never sent.
- R3: Sync and data are sampled only on the selected bit-clock edge. The transmitter changes its line only on the opposite edge.
- R4: A frame starts when the sync, after polarity, is sampled active after having been sampled inactive.
- R5: With delay d, bit 0 of slot 0 is the data sampled d sample edges after the edge that saw the sync start. With d = 0 it is the data sampled on that same edge.
- R6: Bit k of a slot is placed at word position k when LSB first is set, and at position width-1-k otherwise.
- R7: A slot whose mask bit is 0 produces no received word, takes no transmit word, and keeps tx_oe at 0 for its whole duration.
- R8: The transmit bit for a given frame position is placed on tx_sd, with tx_oe at 1, at the launch edge that follows the sample edge of that position. A far end sampling on the same edge therefore sees it one bit period later.
- R9: If a used slot starts while the holding register is empty, the slot sends all ones and tx_underrun becomes 1 and stays 1.
- R10: If a received word completes while the previous word is still held without a handshake, the held word is kept and rx_overrun becomes 1 and stays 1.
- R11: A sync start that arrives before the frame has ended restarts the frame at slot 0 and sets that section's sync-error flag, which stays 1.
- R12: After the last slot's last bit, a section ignores the line (no word, tx_oe 0) until the next sync start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cfg | input | 13 | Receive settings (layout in R2) |
| rx_mask | input | 128 | Receive per-slot use mask |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_sd | input | 1 | Receive serial data |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_overrun | output | 1 | Sticky receive overrun |
| rx_sync_err | output | 1 | Sticky early sync on receive |
| tx_cfg | input | 13 | Transmit settings (layout in R2) |
| tx_mask | input | 128 | Transmit per-slot use mask |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_data | input | 16 | Word to send |
| tx_valid | input | 1 | Word to send is offered |
| tx_ready | output | 1 | Holding register is empty |
| tx_sd | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit line enable (0 = high impedance) |
| tx_underrun | output | 1 | Sticky transmit underrun |
| tx_sync_err | output | 1 | Sticky early sync on transmit |

## Verification
The hardest case to reach is a sync start in the middle of a frame while the transmitter has already used a word from its holding register. The next frame must begin at slot 0 with the following queued word and with no leftover bits. The stimulus gets there by stopping the bench's serial model a few bits into slot 0 of a frame. It then starts a complete frame on the very next bit period, with three words queued. Serial traffic is produced by a bit-level model that drives both clock polarities, both sync polarities and every delay. It places data relative to the sync so that a one-bit error in the delay count or in the transmit latency shows up as a wrong word.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int SLOT_W = 7;
    localparam int WORD_W = 16;
    localparam int CFG_W  = SLOT_W + 6;

    typedef logic [WORD_W-1:0] word_t;

    // Field order fixes the bit layout seen at the configuration ports.
    typedef struct packed {
        logic              smp_rise;
        logic              fs_high;
        logic              lsb_first;
        logic              wide;
        logic [1:0]        delay;
        logic [SLOT_W-1:0] last_slot;
    } port_cfg_t;

    typedef enum logic [1:0] {FR_IDLE, FR_WAIT, FR_RUN} fr_state_t;

    // Position reported by the framer on a sample strobe.
    typedef struct packed {
        logic              ev;
        logic [SLOT_W-1:0] slot;
        logic [3:0]        bit_n;
        logic              last_bit;
    } slot_pos_t;

    function automatic logic [3:0] bit_pos(port_cfg_t c, logic [3:0] b);
        if (c.lsb_first) return b;
        return c.wide ? 4'd15 - b : 4'd7 - b;
    endfunction

endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
    import tdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_cfg_t cfg,
    input  logic      smp,
    input  logic      fs_s,
    output slot_pos_t pos,
    output logic      sync_err
);
    fr_state_t         st, st_n;
    logic [1:0]        wcnt, wcnt_n;
    logic [SLOT_W-1:0] slot, slot_n, cur_slot;
    logic [3:0]        bitc, bit_n, cur_bit;
    logic              fs_prev, fs_act, fs_start, start, ev, last;

    assign fs_act   = cfg.fs_high ? fs_s : ~fs_s;
    assign fs_start = smp && fs_act && !fs_prev;

    always_comb begin
        start  = 1'b0;
        ev     = 1'b0;
        st_n   = st;
        wcnt_n = wcnt;
        slot_n = slot;
        bit_n  = bitc;
        if (fs_start) begin
            if (cfg.delay == 2'd0) start = 1'b1;
            else begin
                st_n   = FR_WAIT;
                wcnt_n = cfg.delay;
            end
        end else if (smp && st == FR_WAIT) begin
            if (wcnt == 2'd1) start = 1'b1;
            else wcnt_n = wcnt - 2'd1;
        end else if (smp && st == FR_RUN) begin
            ev = 1'b1;
        end
        if (start) ev = 1'b1;
        cur_slot = start ? '0 : slot;
        cur_bit  = start ? '0 : bitc;
        last     = cur_bit == (cfg.wide ? 4'd15 : 4'd7);
        if (ev) begin
            if (last) begin
                bit_n = '0;
                if (cur_slot == cfg.last_slot) begin
                    st_n   = FR_IDLE;
                    slot_n = '0;
                end else begin
                    st_n   = FR_RUN;
                    slot_n = cur_slot + 1'b1;
                end
            end else begin
                st_n   = FR_RUN;
                slot_n = cur_slot;
                bit_n  = cur_bit + 4'd1;
            end
        end
    end

    assign pos = '{ev: ev, slot: cur_slot, bit_n: cur_bit, last_bit: last};

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FR_IDLE;
            wcnt     <= '0;
            slot     <= '0;
            bitc     <= '0;
            fs_prev  <= 1'b1;
            sync_err <= 1'b0;
        end else begin
            st   <= st_n;
            wcnt <= wcnt_n;
            slot <= slot_n;
            bitc <= bit_n;
            if (smp) fs_prev <= fs_act;
            if (fs_start && st != FR_IDLE) sync_err <= 1'b1;
        end
    end

    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        st == FR_RUN |-> slot <= cfg.last_slot); // R12
    AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st == FR_WAIT |-> wcnt != 2'd0); // R5
    AST_SYNC_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> sync_err); // R11
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  port_cfg_t            cfg,
    input  logic [MAX_SLOTS-1:0] mask,
    input  logic                 bclk,
    input  logic                 fs,
    input  logic                 sd,
    output word_t                data,
    output logic                 valid,
    input  logic                 ready,
    output logic                 overrun,
    output logic                 sync_err
);
    logic [2:0] sq;
    logic       bclk_d, smp, active, deliver;
    slot_pos_t  pos;
    word_t      acc, acc_n;

    tdm_sync #(.W(3)) u_sync (.clk(clk), .rst(rst), .d({bclk, fs, sd}), .q(sq));

    always_ff @(posedge clk) bclk_d <= rst ? 1'b0 : sq[2];

    assign smp = cfg.smp_rise ? (sq[2] & ~bclk_d) : (~sq[2] & bclk_d);

    tdm_framer u_framer (
        .clk(clk), .rst(rst), .cfg(cfg), .smp(smp), .fs_s(sq[1]),
        .pos(pos), .sync_err(sync_err)
    );

    assign active  = mask[pos.slot];
    assign deliver = pos.ev && active && pos.last_bit;

    always_comb begin
        acc_n = (pos.bit_n == 4'd0) ? '0 : acc;
        acc_n[bit_pos(cfg, pos.bit_n)] = sq[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            data    <= '0;
            valid   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (pos.ev && active) acc <= acc_n;
            if (valid && ready) valid <= 1'b0;
            if (deliver) begin
                if (valid && !ready) overrun <= 1'b1;
                else begin
                    data  <= acc_n;
                    valid <= 1'b1;
                end
            end
        end
    end

    AST_RX_KEEP_WORD: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(data)); // R10
    AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  port_cfg_t            cfg,
    input  logic [MAX_SLOTS-1:0] mask,
    input  logic                 bclk,
    input  logic                 fs,
    input  word_t                data,
    input  logic                 valid,
    output logic                 ready,
    output logic                 sd,
    output logic                 oe,
    output logic                 underrun,
    output logic                 sync_err
);
    logic [1:0] sq;
    logic       bclk_d, smp, lau, active, load, full, nb, noe;
    slot_pos_t  pos;
    word_t      hold, sreg, cur;

    tdm_sync #(.W(2)) u_sync (.clk(clk), .rst(rst), .d({bclk, fs}), .q(sq));

    always_ff @(posedge clk) bclk_d <= rst ? 1'b0 : sq[1];

    assign smp = cfg.smp_rise ? (sq[1] & ~bclk_d) : (~sq[1] & bclk_d);
    assign lau = cfg.smp_rise ? (~sq[1] & bclk_d) : (sq[1] & ~bclk_d);

    tdm_framer u_framer (
        .clk(clk), .rst(rst), .cfg(cfg), .smp(smp), .fs_s(sq[0]),
        .pos(pos), .sync_err(sync_err)
    );

    assign active = mask[pos.slot];
    assign load   = pos.ev && active && pos.bit_n == 4'd0;
    assign cur    = load ? (full ? hold : '1) : sreg;
    assign ready  = !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            full     <= 1'b0;
            sreg     <= '0;
            underrun <= 1'b0;
            nb       <= 1'b0;
            noe      <= 1'b0;
            sd       <= 1'b0;
            oe       <= 1'b0;
        end else begin
            if (valid && !full) begin
                hold <= data;
                full <= 1'b1;
            end
            if (load) begin
                sreg <= cur;
                if (full) full <= 1'b0;
                else underrun <= 1'b1;
            end
            if (smp) begin
                noe <= pos.ev && active;
                nb  <= pos.ev && active && cur[bit_pos(cfg, pos.bit_n)];
            end
            if (lau) begin
                sd <= nb;
                oe <= noe;
            end
        end
    end

    AST_TX_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lau |=> $stable(sd) && $stable(oe)); // R3
    AST_TX_UDR_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R9
endmodule

// File: rtl/tdm_port.sv
module tdm_port
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CFG_W-1:0]     rx_cfg,
    input  logic [MAX_SLOTS-1:0] rx_mask,
    input  logic                 rx_bclk,
    input  logic                 rx_fs,
    input  logic                 rx_sd,
    output logic [WORD_W-1:0]    rx_data,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic                 rx_overrun,
    output logic                 rx_sync_err,
    input  logic [CFG_W-1:0]     tx_cfg,
    input  logic [MAX_SLOTS-1:0] tx_mask,
    input  logic                 tx_bclk,
    input  logic                 tx_fs,
    input  logic [WORD_W-1:0]    tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic                 tx_sd,
    output logic                 tx_oe,
    output logic                 tx_underrun,
    output logic                 tx_sync_err
);
    port_cfg_t rx_c, tx_c;
    assign rx_c = port_cfg_t'(rx_cfg);
    assign tx_c = port_cfg_t'(tx_cfg);

    tdm_rx #(.MAX_SLOTS(MAX_SLOTS)) u_rx (
        .clk(clk), .rst(rst), .cfg(rx_c), .mask(rx_mask),
        .bclk(rx_bclk), .fs(rx_fs), .sd(rx_sd),
        .data(rx_data), .valid(rx_valid), .ready(rx_ready),
        .overrun(rx_overrun), .sync_err(rx_sync_err)
    );

    tdm_tx #(.MAX_SLOTS(MAX_SLOTS)) u_tx (
        .clk(clk), .rst(rst), .cfg(tx_c), .mask(tx_mask),
        .bclk(tx_bclk), .fs(tx_fs),
        .data(tx_data), .valid(tx_valid), .ready(tx_ready),
        .sd(tx_sd), .oe(tx_oe),
        .underrun(tx_underrun), .sync_err(tx_sync_err)
    );

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !rx_valid && !tx_oe && tx_ready); // R1
endmodule

// File: tb/tdm_port_tb.sv
`timescale 1ns/1ps
module tdm_port_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [12:0]  cfg = 13'h1801;
    logic [127:0] mask = '1;
    logic         ph = 1'b1, fs_act = 1'b0, sd_line = 1'b0;
    logic         bclk, fs_line;
    logic [15:0]  rx_data, tx_data = '0;
    logic         rx_valid, rx_ready = 1'b1, rx_overrun, rx_sync_err;
    logic         tx_valid = 1'b0, tx_ready, tx_sd, tx_oe, tx_underrun, tx_sync_err;

    int tests = 0, fails = 0;
    logic [15:0] rx_got [0:7];
    int rx_n = 0;
    logic        rx_rdy_en = 1'b1;
    logic [15:0] txq [0:7];
    int tx_qn = 0, tx_qi = 0;
    logic        tx_pend = 1'b0;
    logic [15:0] rx_words [0:3];
    logic [15:0] tx_cap [0:3];
    int oe_cnt [0:3];
    int stray = 0;

    always #2.5 clk = ~clk;

    assign bclk    = cfg[12] ? ph : ~ph;
    assign fs_line = cfg[11] ? fs_act : ~fs_act;

    tdm_port u_dut (
        .clk(clk), .rst(rst),
        .rx_cfg(cfg), .rx_mask(mask), .rx_bclk(bclk), .rx_fs(fs_line), .rx_sd(sd_line),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_sync_err(rx_sync_err),
        .tx_cfg(cfg), .tx_mask(mask), .tx_bclk(bclk), .tx_fs(fs_line),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_sd(tx_sd), .tx_oe(tx_oe), .tx_underrun(tx_underrun), .tx_sync_err(tx_sync_err)
    );

    // Vector layout: {cfg[12:0], slot0 word, slot1 word}; cfg = {rise, fs_high, lsb, wide, delay, last_slot}
    localparam int NV = 6;
    localparam logic [44:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 7'd1, 16'hA5C3, 16'h1234},
        {1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 7'd1, 16'h8001, 16'h7FFE},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 7'd1, 16'hC001, 16'h0F0F},
        {1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 7'd1, 16'hFF5A, 16'h12C3},
        {1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 7'd1, 16'h0081, 16'h003E},
        {1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 7'd1, 16'h0001, 16'h8000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (tx_pend) tx_qi++;
        tx_valid = tx_qi < tx_qn;
        tx_data  = txq[tx_qi % 8];
        tx_pend  = tx_valid && tx_ready;
        rx_ready = rx_rdy_en;
        if (rx_valid && rx_ready) begin
            rx_got[rx_n % 8] = rx_data;
            rx_n++;
        end
    endtask

    task automatic period(input logic fsv, input logic dv, output logic s, output logic o);
        ph = 1'b0; fs_act = fsv; sd_line = dv;
        repeat (8) tick();
        s = tx_sd; o = tx_oe;
        ph = 1'b1;
        repeat (8) tick();
    endtask

    function automatic int bpos(input int b, input int w);
        return cfg[10] ? b : w - 1 - b;
    endfunction

    task automatic frame(input int cut, input int idle, input int tail);
        int w, d, n, total;
        logic s, o;
        w = cfg[9] ? 16 : 8;
        d = int'(cfg[8:7]);
        n = int'(cfg[6:0]) + 1;
        for (int i = 0; i < 4; i++) begin tx_cap[i] = '0; oe_cnt[i] = 0; end
        stray = 0;
        repeat (idle) period(1'b0, 1'b0, s, o);
        total = (cut > 0) ? cut : d + n * w + 1;
        for (int j = 0; j < total; j++) begin
            int p, q;
            logic dv;
            p  = j - d;
            dv = (p >= 0 && p < n * w) ? rx_words[p / w][bpos(p % w, w)] : 1'b0;
            period(j == 0, dv, s, o);
            q = j - 1 - d;
            if (q >= 0 && q < n * w) begin
                tx_cap[q / w][bpos(q % w, w)] = s;
                if (o) oe_cnt[q / w]++;
            end else if (o) stray++;
        end
        for (int t = 0; t < tail; t++) begin
            period(1'b0, 1'b1, s, o);
            if (o) stray++;
        end
        repeat (6) tick();
    endtask

    task automatic setup(input logic [12:0] c, input logic [127:0] m);
        cfg = c; mask = m;
        rx_n = 0; tx_qn = 0; tx_qi = 0; tx_pend = 1'b0; rx_rdy_en = 1'b1;
        fs_act = 1'b0; sd_line = 1'b0; ph = 1'b1;
        rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
        tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R12 watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] wm;
        // R1: reset state
        setup(13'h1A01, '1);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 tx_oe", tx_oe, 0);
        check("R1 tx_ready", tx_ready, 1);
        check("R1 flags", {rx_overrun, rx_sync_err, tx_underrun, tx_sync_err}, 0);

        // Table walk: R2 R3 R4 R5 R6 on receive, R8 on transmit
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][44:32], '1);
            wm = VEC[v][41] ? 16'hFFFF : 16'h00FF;
            rx_words[0] = VEC[v][31:16]; rx_words[1] = VEC[v][15:0];
            txq[0] = VEC[v][31:16]; txq[1] = VEC[v][15:0]; tx_qn = 2;
            frame(0, 2, 0);
            check("R2/R3/R4/R5/R6 rx word count", rx_n, 2);
            check("R2/R3/R4/R5/R6 rx slot0", rx_got[0], rx_words[0] & wm);
            check("R2/R3/R4/R5/R6 rx slot1", rx_got[1], rx_words[1] & wm);
            check("R8 tx slot0", tx_cap[0], rx_words[0] & wm);
            check("R8 tx slot1", tx_cap[1], rx_words[1] & wm);
            check("R8 tx oe slot0", oe_cnt[0], VEC[v][41] ? 16 : 8);
            check("R9/R10/R11 no flags", {rx_overrun, rx_sync_err, tx_underrun, tx_sync_err}, 0);
        end

        // R7: middle slot of three masked off
        setup({1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 7'd2}, ~128'h2);
        rx_words[0] = 16'h11; rx_words[1] = 16'h22; rx_words[2] = 16'h33;
        txq[0] = 16'h44; txq[1] = 16'h55; tx_qn = 2;
        frame(0, 2, 0);
        check("R7 rx count", rx_n, 2);
        check("R7 rx first", rx_got[0], 16'h11);
        check("R7 rx skips slot1", rx_got[1], 16'h33);
        check("R7 tx slot0", tx_cap[0], 16'h44);
        check("R7 tx slot2", tx_cap[2], 16'h55);
        check("R7 tx oe off in slot1", oe_cnt[1], 0);

        // R9: used slot with empty holding register
        setup({1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 7'd0}, '1);
        rx_words[0] = 16'h0;
        frame(0, 2, 0);
        check("R9 all ones", tx_cap[0], 16'hFFFF);
        check("R9 oe driven", oe_cnt[0], 16);
        check("R9 underrun flag", tx_underrun, 1);

        // R10: consumer stalls across two words
        setup({1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 7'd1}, '1);
        rx_rdy_en = 1'b0;
        rx_words[0] = 16'h1111; rx_words[1] = 16'h2222;
        txq[0] = 16'h1; txq[1] = 16'h2; tx_qn = 2;
        frame(0, 2, 0);
        check("R10 still valid", rx_valid, 1);
        check("R10 old word kept", rx_data, 16'h1111);
        check("R10 overrun flag", rx_overrun, 1);
        rx_rdy_en = 1'b1;
        repeat (4) tick();
        check("R10 one word only", rx_n, 1);
        check("R10 word drained", rx_got[0], 16'h1111);

        // R11: sync restarts a frame in slot 0
        setup({1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 7'd1}, '1);
        rx_words[0] = 16'hEE; rx_words[1] = 16'hDD;
        txq[0] = 16'h0F; txq[1] = 16'hA6; txq[2] = 16'h3C; tx_qn = 3;
        frame(6, 2, 0);
        check("R11 no early flag", rx_sync_err, 0);
        rx_words[0] = 16'h96; rx_words[1] = 16'h69;
        frame(0, 0, 0);
        check("R11 rx sync error", rx_sync_err, 1);
        check("R11 tx sync error", tx_sync_err, 1);
        check("R11 rx count", rx_n, 2);
        check("R11 rx slot0", rx_got[0], 16'h96);
        check("R11 rx slot1", rx_got[1], 16'h69);
        check("R11 tx slot0 next word", tx_cap[0], 16'hA6);
        check("R11 tx slot1", tx_cap[1], 16'h3C);

        // R12: line ignored after the last slot
        setup({1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 7'd0}, '1);
        rx_words[0] = 16'h5B;
        txq[0] = 16'h77; txq[1] = 16'h88; tx_qn = 2;
        frame(0, 2, 20);
        check("R12 single word", rx_n, 1);
        check("R12 word", rx_got[0], 16'h5B);
        check("R12 tx quiet after frame", stray, 0);
        check("R12 next word left queued", tx_ready, 0);
        check("R12 no sync error", rx_sync_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule